// File: doc/BRIEF.md
# MDIO Management Controller

This block is a register-mapped master for the two-wire PHY management bus. Software places a command in one access register: the operation, PHY address, register address and write data, with a GO flag set. The block then sends one complete clause-22 management frame on MDC/MDIO. MDIO is a tristate line, shown here as an output value, an output enable and an input. GO stays set until the frame is over. For a read, the same register then returns the 16 data bits and a flag that says whether the PHY answered during turnaround.

MDC comes from the system clock through a programmable divider that sits in the control register. The control register also holds an enable bit and a read-only idle flag. A link bitmap has one bit per PHY address. The block updates it on its own whenever an answered read of a PHY's basic status register (register 1) completes. The bitmap bit then takes the value of data bit 2 of that register. No background polling is performed.

The register interface is a word-addressed port with a single cycle of access. Word 0 is control, word 1 is user access and word 2 is link. Read data appears on `bus_rdata` one clock after a read request and holds until the next read.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, control reads 0x8000_0000 (idle set, enable clear, divider 0), user access reads 0, link reads 0, MDC is low and MDIO is not driven.
- R2: The user-access word uses these bits: bit 31 is GO, bit 30 is write (1) or read (0), bit 29 is ACK, bits 25:21 are the register address, bits 20:16 are the PHY address and bits 15:0 are data. A write with GO set while enabled and idle starts one frame. GO reads 1 until that frame ends and then clears by itself.
- R3: A write to user access while GO is set changes no field and starts no frame.
- R4: While enable is clear, writing GO has no effect: GO reads 0, no frame is sent and MDC stays low.
- R5: A frame consists of at least 32 ones, then start bits 01, then opcode 10 for a read or 01 for a write. The 5-bit PHY address and the 5-bit register address follow, both MSB first. A write then sends turnaround 10 and 16 data bits, MSB first.
- R6: On a read, MDIO is released for both turnaround bits and the data bits. ACK is set only if the PHY drives the second turnaround bit low. The 16 bits sampled are returned in bits 15:0. A write leaves ACK clear.
- R7: While enabled or busy, MDC has a period of 2×(divider+1) system clocks. When disabled and idle, MDC is held low.
- R8: The MDIO output only changes in the same clock in which MDC falls. Input is sampled when MDC rises.
- R9: Control bit 30 is enable and the low 8 bits are the divider. Both read back as written. Bit 31 reads 0 while a frame is pending or in progress.
- R10: When a read of register 1 completes with ACK set, link bit N (N being the PHY address) takes data bit 2. Reads without ACK leave the link word unchanged.
- R11: Clearing enable during a frame does not cut the frame short. The frame completes and GO clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word select: 0 control, 1 user access, 2 link |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read request |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input (pulled up when undriven) |

## Verification
The hardest case to reach from the ports is a second command that arrives while a frame is still on the wire. A related case is enable being withdrawn partway through a frame. Both must leave the frame in flight intact. The stimulus reaches them by issuing the follow-up register write on the very next bus cycle after the command. A pin-level PHY model then counts the frames that actually appear on MDIO. The model can answer or stay silent per address, which is how missing-ACK reads and the link-bit update are exercised.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_USER = 2'd1;
  localparam logic [1:0] ADDR_LINK = 2'd2;

  localparam int B_GO   = 31;
  localparam int B_WR   = 30;
  localparam int B_ACK  = 29;
  localparam int B_IDLE = 31;
  localparam int B_EN   = 30;

  localparam logic [4:0] STATUS_REG = 5'd1;
  localparam int         LINK_BIT   = 2;

  typedef enum logic [1:0] {ENG_IDLE, ENG_WAIT, ENG_SHIFT} eng_state_t;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt;
  logic             mdc_q;
  logic             tick;

  assign tick     = run && (cnt >= div);
  assign rise_stb = tick && !mdc_q;
  assign fall_stb = tick && mdc_q;
  assign mdc      = mdc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R7: MDC only rises through the divider's rise strobe
  p_mdc_rise_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc_q) |-> $past(rise_stb));

  // R7: MDC is held low whenever the divider is not running
  p_mdc_low_stopped_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!run) |-> !mdc_q);
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        idle,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic        rd_ack,
  output logic [15:0] rd_data
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  eng_state_t            st;
  mdio_cmd_t             cmd_q;
  logic [FRAME_BITS-1:0] tx_sr;
  logic [IDX_W-1:0]      idx;
  logic [15:0]           rx_sr;
  logic                  ack_q;
  logic                  oe_q;
  logic                  done_q;

  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c);
    build_frame = {{PRE_BITS{1'b1}}, 2'b01, (c.wr ? 2'b01 : 2'b10),
                   c.phy, c.regad, (c.wr ? 2'b10 : 2'b11),
                   (c.wr ? c.data : 16'hFFFF)};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ENG_IDLE;
      cmd_q  <= '0;
      tx_sr  <= '1;
      idx    <= '0;
      rx_sr  <= '0;
      ack_q  <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ENG_IDLE: begin
          if (start) begin
            cmd_q <= cmd;
            st    <= ENG_WAIT;
          end
        end
        ENG_WAIT: begin
          if (fall_stb) begin
            tx_sr <= build_frame(cmd_q);
            idx   <= '0;
            oe_q  <= 1'b1;
            ack_q <= 1'b0;
            st    <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (rise_stb && !cmd_q.wr) begin
            if (idx == IDX_W'(TA_FIRST + 1))
              ack_q <= ~mdio_i;
            if (idx >= IDX_W'(DATA_FIRST))
              rx_sr <= {rx_sr[14:0], mdio_i};
          end
          if (fall_stb) begin
            if (idx == IDX_W'(FRAME_BITS - 1)) begin
              st     <= ENG_IDLE;
              oe_q   <= 1'b0;
              tx_sr  <= '1;
              done_q <= 1'b1;
            end else begin
              idx   <= idx + 1'b1;
              tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b1};
              oe_q  <= cmd_q.wr || (idx < IDX_W'(TA_FIRST - 1));
            end
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  assign idle    = (st == ENG_IDLE);
  assign mdio_o  = tx_sr[FRAME_BITS-1];
  assign mdio_oe = oe_q;
  assign done    = done_q;
  assign rd_ack  = ack_q;
  assign rd_data = rx_sr;

  // R8: the driven value only moves on a falling MDC strobe
  p_out_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (mdio_o != $past(mdio_o)) |-> $past(fall_stb));

  // R6: line released during turnaround and data of a read
  p_release_on_read_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ENG_SHIFT && !cmd_q.wr && idx >= IDX_W'(TA_FIRST)) |-> !mdio_oe);

  // R6: acknowledge only ever comes from a read frame
  p_ack_read_only_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> !cmd_q.wr);

  // R2: a completion is only reported out of an active frame
  p_done_from_shift_r2: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(st == ENG_SHIFT));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int NUM_PHY = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CTRL_PAD = 30 - DIV_W;

  logic               en_q;
  logic [DIV_W-1:0]   div_q;
  logic               go_q;
  logic               wr_q;
  logic               ack_q;
  logic [4:0]         regad_q;
  logic [4:0]         phy_q;
  logic [15:0]        data_q;
  logic [NUM_PHY-1:0] link_q;
  logic [31:0]        rdata_q;

  logic               wr_ctrl;
  logic               wr_user;
  logic               start;
  mdio_cmd_t          new_cmd;

  logic               rise_stb;
  logic               fall_stb;
  logic               eng_idle;
  logic               eng_done;
  logic               eng_ack;
  logic [15:0]        eng_data;

  logic [31:0]        ctrl_word;
  logic [31:0]        user_word;
  logic [31:0]        link_word;

  assign wr_ctrl = bus_sel && bus_we && (bus_addr == ADDR_CTRL);
  assign wr_user = bus_sel && bus_we && (bus_addr == ADDR_USER);
  assign start   = wr_user && bus_wdata[B_GO] && en_q && !go_q;

  assign new_cmd.wr    = bus_wdata[B_WR];
  assign new_cmd.phy   = bus_wdata[20:16];
  assign new_cmd.regad = bus_wdata[25:21];
  assign new_cmd.data  = bus_wdata[15:0];

  mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .run      (en_q || !eng_idle),
    .div      (div_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_engine u_engine (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cmd      (new_cmd),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .idle     (eng_idle),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (eng_done),
    .rd_ack   (eng_ack),
    .rd_data  (eng_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      div_q <= '0;
    end else if (wr_ctrl) begin
      en_q  <= bus_wdata[B_EN];
      div_q <= bus_wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      go_q    <= 1'b0;
      wr_q    <= 1'b0;
      ack_q   <= 1'b0;
      regad_q <= '0;
      phy_q   <= '0;
      data_q  <= '0;
    end else if (start) begin
      go_q    <= 1'b1;
      wr_q    <= new_cmd.wr;
      ack_q   <= 1'b0;
      regad_q <= new_cmd.regad;
      phy_q   <= new_cmd.phy;
      data_q  <= new_cmd.data;
    end else if (eng_done && go_q) begin
      go_q <= 1'b0;
      if (!wr_q) begin
        ack_q  <= eng_ack;
        data_q <= eng_data;
      end
    end
  end

  for (genvar i = 0; i < NUM_PHY; i++) begin : g_link
    always_ff @(posedge clk) begin
      if (rst)
        link_q[i] <= 1'b0;
      else if (eng_done && go_q && !wr_q && eng_ack &&
               regad_q == STATUS_REG && phy_q == 5'(i))
        link_q[i] <= eng_data[LINK_BIT];
    end
  end

  assign ctrl_word = {eng_idle, en_q, {CTRL_PAD{1'b0}}, div_q};
  assign user_word = {go_q, wr_q, ack_q, 3'b000, regad_q, phy_q, data_q};

  always_comb begin
    link_word              = '0;
    link_word[NUM_PHY-1:0] = link_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_sel && !bus_we) begin
      case (bus_addr)
        ADDR_CTRL: rdata_q <= ctrl_word;
        ADDR_USER: rdata_q <= user_word;
        ADDR_LINK: rdata_q <= link_word;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;

  // R4: a command is only taken while enabled
  p_go_needs_enable_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(go_q) |-> $past(en_q));

  // R2: GO only clears once the engine reports the frame finished
  p_go_clears_on_done_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(go_q) |-> $past(eng_done));

  // R9: idle flag is low while a command is outstanding
  p_busy_not_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (go_q && !eng_done) |-> !eng_idle);

  // R3: command fields hold while GO stays set
  p_cmd_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (go_q && $past(go_q)) |-> $stable({wr_q, regad_q, phy_q}));

  // R10: link bits only move on an acknowledged completion
  p_link_on_ack_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(link_q) |-> $past(eng_done && eng_ack));
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  always #2 clk = ~clk;

  mdio_mgmt_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int mdc_rises = 0;
  int r8_bad = 0;
  int frames_seen = 0;
  int contention = 0;

  always @(posedge clk) cyc++;
  always @(posedge mdc) mdc_rises++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- PHY model and frame monitor ----------------
  typedef struct {
    logic       wr;
    logic [4:0] phy;
    logic [4:0] regad;
    logic [15:0] data;
  } frame_t;

  frame_t      exp_q[$];
  logic [15:0] phy_mem [32][32];
  logic [31:0] phy_present = 32'h0000_0028;
  logic        phy_drive = 1'b0;
  logic        phy_bit = 1'b1;
  assign mdio_i = phy_drive ? phy_bit : 1'b1;

  int          pstate = 0, ones = 0, hcnt = 0, bcnt = 0;
  logic [11:0] hdr = '0;
  logic [15:0] wdat = '0;
  logic        line;

  task automatic frame_end(logic wr, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    frame_t e;
    frames_seen++;
    if (exp_q.size() == 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R3 unexpected frame actual=%h expected=none", {wr, p, r});
    end else begin
      e = exp_q.pop_front();
      check("R5 frame opcode/phy/reg", {21'b0, wr, p, r}, {21'b0, e.wr, e.phy, e.regad});
      if (wr) check("R5 write data on wire", {16'b0, d}, {16'b0, e.data});
    end
  endtask

  always @(posedge mdc) begin
    line = mdio_oe ? mdio_o : mdio_i;
    if (mdio_oe && phy_drive) contention++;
    case (pstate)
      0: begin
        if (line) ones++;
        else begin
          if (ones >= 32) pstate = 1;
          ones = 0;
        end
      end
      1: begin
        if (line) begin pstate = 2; hcnt = 0; end
        else pstate = 0;
      end
      2: begin
        hdr = {hdr[10:0], line};
        hcnt++;
        if (hcnt == 12) begin pstate = 3; bcnt = 0; end
      end
      default: begin
        if (hdr[11:10] == 2'b01) begin
          if (bcnt == 0 && line !== 1'b1) check("R5 write TA bit1", {31'b0, line}, 1);
          if (bcnt == 1 && line !== 1'b0) check("R5 write TA bit2", {31'b0, line}, 0);
          if (bcnt >= 2) wdat = {wdat[14:0], line};
          if (bcnt == 17) begin
            phy_mem[hdr[9:5]][hdr[4:0]] = wdat;
            frame_end(1'b1, hdr[9:5], hdr[4:0], wdat);
            pstate = 0; ones = 0;
          end
        end else begin
          if (phy_present[hdr[9:5]]) begin
            if (bcnt == 0) begin phy_drive = 1'b1; phy_bit = 1'b0; end
            else if (bcnt <= 16) phy_bit = phy_mem[hdr[9:5]][hdr[4:0]][16 - bcnt];
          end
          if (bcnt == 17) begin
            phy_drive = 1'b0;
            frame_end(1'b0, hdr[9:5], hdr[4:0], 16'h0);
            pstate = 0; ones = 0;
          end
        end
        bcnt++;
      end
    endcase
  end

  // R8: output changes only together with a falling MDC
  logic prev_o = 1'b1, prev_mdc = 1'b0;
  always @(negedge clk) begin
    if (!rst && (mdio_o !== prev_o) && !(prev_mdc && !mdc)) r8_bad++;
    prev_o = mdio_o;
    prev_mdc = mdc;
  end

  // ---------------- bus driver ----------------
  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] cmd_word(logic wr, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    return {1'b1, wr, 1'b0, 3'b000, r, p, d};
  endfunction

  task automatic push_exp(logic wr, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    frame_t e;
    e.wr = wr; e.phy = p; e.regad = r; e.data = d;
    exp_q.push_back(e);
  endtask

  task automatic poll_done(output logic [31:0] fin);
    fin = 32'hFFFF_FFFF;
    for (int i = 0; i < 3000; i++) begin
      bus_read(2'd1, fin);
      if (!fin[31]) break;
    end
  endtask

  task automatic do_access(logic wr, logic [4:0] p, logic [4:0] r, logic [15:0] d,
                           output logic [31:0] fin);
    logic [31:0] c;
    push_exp(wr, p, r, d);
    bus_write(2'd1, cmd_word(wr, p, r, d));
    bus_read(2'd0, c);
    check("R9 idle low and enable high while busy", {30'b0, c[31:30]}, 32'd1);
    poll_done(fin);
  endtask

  function automatic logic [31:0] exp_read(logic [4:0] p, logic [4:0] r);
    logic a;
    a = phy_present[p];
    return {2'b00, a, 3'b000, r, p, (a ? phy_mem[p][r] : 16'hFFFF)};
  endfunction

  bit ended = 0;
  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] d, e;
    int t0, t1, r0;
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++) phy_mem[i][j] = 16'h0000;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(2'd0, d); check("R1 control after reset", d, 32'h8000_0000);
    bus_read(2'd1, d); check("R1 user access after reset", d, 32'h0);
    bus_read(2'd2, d); check("R1 link after reset", d, 32'h0);
    check("R1 mdc/oe after reset", {30'b0, mdc, mdio_oe}, 32'h0);

    // R4 GO while disabled
    r0 = mdc_rises;
    bus_write(2'd1, cmd_word(1'b1, 5'd5, 5'd9, 16'h1111));
    repeat (60) @(negedge clk);
    bus_read(2'd1, d); check("R4 GO ignored while disabled", d, 32'h0);
    check("R4 no MDC activity while disabled", mdc_rises - r0, 0);

    // R7 / R9 divider
    bus_write(2'd0, 32'h4000_0003);
    @(posedge mdc); @(posedge mdc); t0 = cyc; @(posedge mdc); t1 = cyc;
    check("R7 MDC period div=3", t1 - t0, 8);
    bus_read(2'd0, d); check("R9 control readback", d, 32'hC000_0003);
    bus_write(2'd0, 32'h4000_0001);
    @(posedge mdc); @(posedge mdc); t0 = cyc; @(posedge mdc); t1 = cyc;
    check("R7 MDC period div=1", t1 - t0, 4);

    // R2 / R5 write
    do_access(1'b1, 5'd5, 5'd9, 16'hA5C3, d);
    check("R2 write completes, GO clear", d, {3'b010, 3'b000, 5'd9, 5'd5, 16'hA5C3});
    check("R5 PHY received write data", {16'b0, phy_mem[5][9]}, 32'h0000_A5C3);

    // R6 read present PHY
    do_access(1'b0, 5'd5, 5'd9, 16'h0, d);
    check("R6 read of present PHY", d, exp_read(5'd5, 5'd9));

    // R6 read absent PHY
    do_access(1'b0, 5'd7, 5'd9, 16'h0, d);
    check("R6 read of absent PHY no ACK", d, exp_read(5'd7, 5'd9));

    // R10 link update
    phy_mem[3][1] = 16'h7864;
    do_access(1'b0, 5'd3, 5'd1, 16'h0, d);
    check("R10 status read data", d, exp_read(5'd3, 5'd1));
    bus_read(2'd2, d); check("R10 link bit set", d, 32'h0000_0008);
    do_access(1'b0, 5'd7, 5'd1, 16'h0, d);
    bus_read(2'd2, d); check("R10 link unchanged on no ACK", d, 32'h0000_0008);
    phy_mem[3][1] = 16'h7860;
    do_access(1'b0, 5'd3, 5'd1, 16'h0, d);
    bus_read(2'd2, d); check("R10 link bit cleared", d, 32'h0000_0000);

    // R3 command while busy
    phy_mem[5][2] = 16'h3C5A;
    push_exp(1'b0, 5'd5, 5'd2, 16'h0);
    bus_write(2'd1, cmd_word(1'b0, 5'd5, 5'd2, 16'h0));
    bus_write(2'd1, cmd_word(1'b1, 5'd3, 5'd6, 16'h1234));
    poll_done(d);
    check("R3 busy write ignored, first read intact", d, exp_read(5'd5, 5'd2));
    repeat (400) @(negedge clk);
    check("R3 no extra frame sent", {31'b0, exp_q.size() == 0}, 1);
    check("R3 PHY register untouched", {16'b0, phy_mem[3][6]}, 32'h0);

    // R11 disable mid-frame
    push_exp(1'b1, 5'd5, 5'd4, 16'h0F0F);
    bus_write(2'd1, cmd_word(1'b1, 5'd5, 5'd4, 16'h0F0F));
    bus_write(2'd0, 32'h0000_0001);
    poll_done(d);
    check("R11 frame completes after disable", d, {3'b010, 3'b000, 5'd4, 5'd5, 16'h0F0F});
    check("R11 PHY received data", {16'b0, phy_mem[5][4]}, 32'h0000_0F0F);
    repeat (10) @(negedge clk);
    r0 = mdc_rises;
    repeat (50) @(negedge clk);
    check("R7 MDC stopped when disabled and idle", {31'b0, mdc}, 0);
    check("R7 no MDC rises when disabled", mdc_rises - r0, 0);
    bus_read(2'd0, d); check("R9 idle with enable clear", d, 32'h8000_0001);

    check("R8 output moved only on MDC fall", r8_bad, 0);
    check("R6 no bus contention", contention, 0);
    check("R5 frame count", frames_seen, 8);
    finish_run();
  end
endmodule